// File: doc/BRIEF.md
# SDRAM Control Register and Power Sequencer

This block holds the 16-bit control and status word of an SDRAM controller and runs the sequences that the word requests. Software writes the word through a simple register port and reads it back at once. The memory access path presents each access on a request port. The block answers by stalling that access, by inserting a read wait state, or by using the access as the trigger for power-up initialization.

Setting the initialization enable only arms the power-up sequence. The next write access to SDRAM space is taken as a dummy and starts it. The block then issues precharge-all, a parameterised number of auto-refresh commands, and a mode-register load. Each command is held until the command engine acknowledges it. When the mode-register load is acknowledged, the active status bit rises.

A go-to-sleep bit requests a power-down with the contents kept by self-refresh. Clearing that bit while asleep requests the exit. The remaining bits select the read-data register stage and the clock inversion, which set the wait-state policy. They also carry the column and bank selects that the address multiplexer uses.

Top module: `sdctl_seq`

## Requirements
- R1: After reset the register reads 0x0000, no command or power request is asserted, no access is stalled and the configuration-error output is low.
- R2: A register write stores bits 14:13 (column select), 10:8 (bank select), 7 (go-to-sleep), 4 (registered read), 3 (clock invert) and 0 (init enable). The word reads back with the stored bits in the same positions. Bits 15, 12:11 and 6:5 read 0, and writes to status bits 2 (sleep) and 1 (active) have no effect on their value.
- R3: With init enable set and active low, neither idle cycles nor read accesses start initialization. The first write access starts it, and precharge-all is asserted from the next cycle.
- R4: Initialization asserts precharge-all, then two auto-refresh commands (the default), then mode-register load. At most one of these is asserted at a time, and each one stays asserted until a cycle with the command acknowledge high.
- R5: Active (bit 1) reads 1 from the cycle after the mode-register load is acknowledged. Any register write clears it.
- R6: When go-to-sleep is 1 and no initialization is running, the self-refresh entry request rises one cycle after go-to-sleep is stored. The request holds until the power-down acknowledge is seen. Sleep status (bit 2) rises only after that acknowledge.
- R7: Clearing go-to-sleep while asleep raises the self-refresh exit request one cycle after the write. The request holds until the power-down acknowledge is seen, and sleep status stays 1 until that acknowledge and clears after it.
- R8: Accesses are stalled during initialization and from the start of sleep entry until the exit is acknowledged.
- R9: The read wait-state output is high only for a read request marked as single or first burst beat while registered read is in effect. It is low for later burst beats and for writes.
- R10: The read pipeline enable equals the stored registered-read bit. The clock-invert output equals clock invert AND NOT registered read, so the illegal pair behaves as registered read with no inversion.
- R11: A register write with bits 4 and 3 both 1, or with a bank select of 000, 110 or 111, sets the configuration-error output. It stays set until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Register read data |
| acc_req | input | 1 | Memory access request |
| acc_wr | input | 1 | Access is a write |
| acc_first | input | 1 | Access is a single transfer or first burst beat |
| acc_stall | output | 1 | Hold the current access |
| rd_wait | output | 1 | Insert one read wait state |
| cmd_pre | output | 1 | Precharge-all command request |
| cmd_ref | output | 1 | Auto-refresh command request |
| cmd_mrs | output | 1 | Mode-register load request |
| cmd_ack | input | 1 | Command engine acknowledge |
| sr_enter_req | output | 1 | Power-down / self-refresh entry request |
| sr_exit_req | output | 1 | Self-refresh exit request |
| pd_ack | input | 1 | Power-down handshake acknowledge |
| rd_pipe_en | output | 1 | Read-data register stage enable |
| clk_inv | output | 1 | Invert SDRAM clock output |
| max_col_sel | output | 2 | Stored column select |
| bank_sel | output | 3 | Stored bank select |
| cfg_err | output | 1 | Sticky configuration error |

## Verification
The state that is hardest to reach from the ports is the middle of the sleep handshake: the exit request is pending and sleep status still reads 1. Getting there needs a completed entry acknowledge and then a register write that clears go-to-sleep. The bench drives that order directly and holds the acknowledge low for several cycles at each step, so the held requests and the stall can be observed. Field storage and the wait-state policy are swept over every 16-bit write value, and the expected read-back and outputs are computed from masks.

// File: rtl/sdctl_seq.sv
module sdctl_seq #(
  parameter int REFS = 2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_wr,
  input  logic [15:0] reg_wdata,
  output logic [15:0] reg_rdata,
  input  logic        acc_req,
  input  logic        acc_wr,
  input  logic        acc_first,
  output logic        acc_stall,
  output logic        rd_wait,
  output logic        cmd_pre,
  output logic        cmd_ref,
  output logic        cmd_mrs,
  input  logic        cmd_ack,
  output logic        sr_enter_req,
  output logic        sr_exit_req,
  input  logic        pd_ack,
  output logic        rd_pipe_en,
  output logic        clk_inv,
  output logic [1:0]  max_col_sel,
  output logic [2:0]  bank_sel,
  output logic        cfg_err
);
  localparam int CW = $clog2(REFS + 1);

  typedef enum logic [1:0] {I_IDLE, I_PRE, I_REF, I_MRS} init_st_t;
  typedef enum logic [1:0] {S_AWAKE, S_ENTER, S_ASLEEP, S_EXIT} slp_st_t;

  init_st_t ist;
  slp_st_t  sst;
  logic [CW-1:0] rcnt;
  logic [1:0] mcol;
  logic [2:0] bank;
  logic gsl, rreg, inv, init_en, act, err;

  logic wr_bad;
  assign wr_bad = (reg_wdata[4] & reg_wdata[3]) |
                  (reg_wdata[10:8] == 3'b000) |
                  (reg_wdata[10:8] == 3'b110) |
                  (reg_wdata[10:8] == 3'b111);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ist <= I_IDLE;
      sst <= S_AWAKE;
      rcnt <= '0;
      mcol <= '0;
      bank <= '0;
      gsl <= 1'b0;
      rreg <= 1'b0;
      inv <= 1'b0;
      init_en <= 1'b0;
      act <= 1'b0;
      err <= 1'b0;
    end else begin
      case (ist)
        I_IDLE:
          if (init_en && !act && sst == S_AWAKE && acc_req && acc_wr)
            ist <= I_PRE;
        I_PRE:
          if (cmd_ack) begin
            ist <= I_REF;
            rcnt <= '0;
          end
        I_REF:
          if (cmd_ack) begin
            if (rcnt == CW'(REFS - 1)) ist <= I_MRS;
            else rcnt <= rcnt + 1'b1;
          end
        I_MRS:
          if (cmd_ack) begin
            ist <= I_IDLE;
            act <= 1'b1;
          end
        default: ist <= I_IDLE;
      endcase

      case (sst)
        S_AWAKE:  if (gsl && ist == I_IDLE) sst <= S_ENTER;
        S_ENTER:  if (pd_ack) sst <= S_ASLEEP;
        S_ASLEEP: if (!gsl) sst <= S_EXIT;
        S_EXIT:   if (pd_ack) sst <= S_AWAKE;
        default:  sst <= S_AWAKE;
      endcase

      if (reg_wr) begin
        mcol <= reg_wdata[14:13];
        bank <= reg_wdata[10:8];
        gsl <= reg_wdata[7];
        rreg <= reg_wdata[4];
        inv <= reg_wdata[3];
        init_en <= reg_wdata[0];
        act <= 1'b0;
        if (wr_bad) err <= 1'b1;
      end
    end
  end

  logic sleep_st;
  assign sleep_st = (sst == S_ASLEEP) | (sst == S_EXIT);

  assign reg_rdata = {1'b0, mcol, 2'b00, bank, gsl, 2'b00, rreg, inv,
                      sleep_st, act, init_en};

  assign cmd_pre = (ist == I_PRE);
  assign cmd_ref = (ist == I_REF);
  assign cmd_mrs = (ist == I_MRS);
  assign sr_enter_req = (sst == S_ENTER);
  assign sr_exit_req  = (sst == S_EXIT);
  assign acc_stall = (ist != I_IDLE) | (sst != S_AWAKE);

  assign rd_pipe_en = rreg;
  assign clk_inv = inv & ~rreg;
  assign rd_wait = acc_req & ~acc_wr & acc_first & rreg;
  assign max_col_sel = mcol;
  assign bank_sel = bank;
  assign cfg_err = err;
endmodule

module sdctl_seq_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        reg_wr,
  input logic [15:0] reg_rdata,
  input logic        acc_stall,
  input logic        cmd_pre,
  input logic        cmd_ref,
  input logic        cmd_mrs,
  input logic        cmd_ack,
  input logic        sr_enter_req,
  input logic        sr_exit_req,
  input logic        pd_ack,
  input logic        rd_pipe_en,
  input logic        clk_inv,
  input logic        cfg_err
);
  a_r4_onehot: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({cmd_pre, cmd_ref, cmd_mrs}));
  a_r4_pre_hold: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_pre && !cmd_ack |=> cmd_pre);
  a_r4_mrs_hold: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_mrs && !cmd_ack |=> cmd_mrs);
  a_r5_act_clear: assert property (@(posedge clk) disable iff (!rst_n)
    reg_wr |=> !reg_rdata[1]);
  a_r6_sleep_after_ack: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(reg_rdata[2]) |-> $past(sr_enter_req && pd_ack));
  a_r7_exit_hold: assert property (@(posedge clk) disable iff (!rst_n)
    sr_exit_req && !pd_ack |=> sr_exit_req && reg_rdata[2]);
  a_r8_stall: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_pre | cmd_ref | cmd_mrs | sr_enter_req | sr_exit_req) |-> acc_stall);
  a_r10_no_inv_pipe: assert property (@(posedge clk) disable iff (!rst_n)
    !(rd_pipe_en && clk_inv));
  a_r11_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_err |=> cfg_err);
endmodule

bind sdctl_seq sdctl_seq_chk chk_i (
  .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rdata(reg_rdata),
  .acc_stall(acc_stall), .cmd_pre(cmd_pre), .cmd_ref(cmd_ref),
  .cmd_mrs(cmd_mrs), .cmd_ack(cmd_ack), .sr_enter_req(sr_enter_req),
  .sr_exit_req(sr_exit_req), .pd_ack(pd_ack), .rd_pipe_en(rd_pipe_en),
  .clk_inv(clk_inv), .cfg_err(cfg_err)
);

// File: tb/sdctl_seq_tb.sv
module sdctl_seq_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic reg_wr = 1'b0;
  logic [15:0] reg_wdata = '0;
  logic [15:0] reg_rdata;
  logic acc_req = 1'b0, acc_wr = 1'b0, acc_first = 1'b0;
  logic acc_stall, rd_wait, cmd_pre, cmd_ref, cmd_mrs;
  logic cmd_ack = 1'b0, pd_ack = 1'b0;
  logic sr_enter_req, sr_exit_req, rd_pipe_en, clk_inv, cfg_err;
  logic [1:0] max_col_sel;
  logic [2:0] bank_sel;

  int vecs = 0;
  int errs = 0;
  bit done = 0;

  always #4 clk = ~clk;

  sdctl_seq dut_i (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .acc_req(acc_req), .acc_wr(acc_wr),
    .acc_first(acc_first), .acc_stall(acc_stall), .rd_wait(rd_wait),
    .cmd_pre(cmd_pre), .cmd_ref(cmd_ref), .cmd_mrs(cmd_mrs),
    .cmd_ack(cmd_ack), .sr_enter_req(sr_enter_req),
    .sr_exit_req(sr_exit_req), .pd_ack(pd_ack), .rd_pipe_en(rd_pipe_en),
    .clk_inv(clk_inv), .max_col_sel(max_col_sel), .bank_sel(bank_sel),
    .cfg_err(cfg_err)
  );

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    vecs++;
    if (got !== exp) begin
      errs++;
      $display("FAIL %s got=%h exp=%h", req, got, exp);
    end
  endtask

  task automatic wr(input logic [15:0] v);
    reg_wr = 1'b1;
    reg_wdata = v;
    step();
    reg_wr = 1'b0;
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    reg_wr = 0; acc_req = 0; acc_wr = 0; acc_first = 0; cmd_ack = 0; pd_ack = 0;
    step(); step();
    rst_n = 1'b1;
  endtask

  initial begin
    do_reset();
    chk("R1 rdata", reg_rdata, 0);
    chk("R1 cmds", {cmd_pre, cmd_ref, cmd_mrs, sr_enter_req, sr_exit_req}, 0);
    chk("R1 stall", acc_stall, 0);
    chk("R1 err", cfg_err, 0);

    wr(16'h0100);
    chk("R11 valid write", cfg_err, 0);
    wr(16'h0118);
    chk("R11 rr+inv", cfg_err, 1);
    chk("R10 illegal pair inv", clk_inv, 0);
    chk("R10 illegal pair pipe", rd_pipe_en, 1);
    wr(16'h0100);
    chk("R11 sticky", cfg_err, 1);
    do_reset();
    wr(16'h0600);
    chk("R11 bank 110", cfg_err, 1);
    do_reset();
    wr(16'h0000);
    chk("R11 bank 000", cfg_err, 1);
    do_reset();

    // R3 dummy write arms and starts init
    wr(16'h0101);
    repeat (3) step();
    chk("R3 idle no start", cmd_pre, 0);
    acc_req = 1; acc_wr = 0; acc_first = 1;
    step();
    chk("R3 read no start", cmd_pre, 0);
    acc_wr = 1;
    step();
    acc_req = 0; acc_wr = 0;
    chk("R3 write starts", cmd_pre, 1);
    chk("R8 stall in init", acc_stall, 1);
    repeat (3) step();
    chk("R4 pre held", {cmd_pre, cmd_ref, cmd_mrs}, 3'b100);
    cmd_ack = 1; step(); cmd_ack = 0;
    chk("R4 ref1", {cmd_pre, cmd_ref, cmd_mrs}, 3'b010);
    step();
    chk("R4 ref1 held", {cmd_pre, cmd_ref, cmd_mrs}, 3'b010);
    cmd_ack = 1; step(); cmd_ack = 0;
    chk("R4 ref2", {cmd_pre, cmd_ref, cmd_mrs}, 3'b010);
    cmd_ack = 1; step(); cmd_ack = 0;
    chk("R4 mrs", {cmd_pre, cmd_ref, cmd_mrs}, 3'b001);
    chk("R5 not yet active", reg_rdata[1], 0);
    cmd_ack = 1; step(); cmd_ack = 0;
    chk("R4 done", {cmd_pre, cmd_ref, cmd_mrs}, 3'b000);
    chk("R5 active", reg_rdata[1], 1);
    chk("R8 no stall", acc_stall, 0);
    wr(16'h0100);
    chk("R5 write clears active", reg_rdata[1], 0);

    // R6/R7 sleep handshake
    wr(16'h0180);
    chk("R6 no req yet", sr_enter_req, 0);
    step();
    chk("R6 enter req", sr_enter_req, 1);
    chk("R8 stall entering", acc_stall, 1);
    repeat (3) step();
    chk("R6 sleep waits ack", reg_rdata[2], 0);
    chk("R6 enter held", sr_enter_req, 1);
    pd_ack = 1; step(); pd_ack = 0;
    chk("R6 sleep set", reg_rdata[2], 1);
    chk("R6 enter dropped", sr_enter_req, 0);
    chk("R8 stall asleep", acc_stall, 1);
    wr(16'h0100);
    chk("R7 no exit yet", sr_exit_req, 0);
    step();
    chk("R7 exit req", sr_exit_req, 1);
    repeat (3) step();
    chk("R7 exit held", sr_exit_req, 1);
    chk("R7 sleep still set", reg_rdata[2], 1);
    chk("R8 stall exiting", acc_stall, 1);
    pd_ack = 1; step(); pd_ack = 0;
    chk("R7 sleep cleared", reg_rdata[2], 0);
    chk("R7 exit dropped", sr_exit_req, 0);
    chk("R8 stall released", acc_stall, 0);

    // R9 burst policy
    wr(16'h0110);
    acc_req = 1; acc_wr = 0; acc_first = 1; #1;
    chk("R9 first beat", rd_wait, 1);
    acc_first = 0; #1;
    chk("R9 later beat", rd_wait, 0);
    acc_wr = 1; acc_first = 1; #1;
    chk("R9 write", rd_wait, 0);
    acc_req = 0; acc_wr = 0; acc_first = 0;

    // R2/R9/R10 sweep over every write value
    do_reset();
    for (int v = 0; v < 65536; v++) begin
      logic [15:0] w;
      w = 16'(v);
      wr(w);
      chk("R2 readback", reg_rdata, {16'(w & 16'h6799)});
      chk("R10 pipe", rd_pipe_en, w[4]);
      chk("R10 inv", clk_inv, w[3] & ~w[4]);
      acc_req = 1; acc_first = 1; #1;
      chk("R9 sweep wait", rd_wait, w[4]);
      acc_req = 0; acc_first = 0;
      chk("R2 fields", {max_col_sel, bank_sel}, {w[14:13], w[10:8]});
    end

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      errs++;
      $display("FAIL watchdog got=timeout exp=finish");
      $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
      $finish;
    end
  end
endmodule